// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error Flags

This block receives asynchronous serial frames on a single input line and samples it on a clock enable that pulses sixteen times per bit period. Each frame is one low start bit, eight data bits sent least significant bit first, an optional parity bit, and one high stop bit. The parity bit is turned on and off by an input, and a second input picks even or odd parity. Received bits collect in a shift register. When the stop bit has been sampled, the block decides whether the word moves into the host-visible data register, and which of four flags to raise: ready, overrun, framing and parity.

The rules for moving the word and setting the flags are fixed.

- When only framing or parity problems occur, the word is still copied but the ready flag stays low.
- Whenever the ready flag is still high as a new frame ends, the new word is dropped. The overrun flag rises, together with any framing or parity flag that applies.

The receiver does not stop during a break. If the line is held low, each following all-zero frame raises the framing flag again after the host has cleared it. The host can read the synchronized line level to tell a break from a single corrupted frame.

Top module: `serial_rx_core`

## Requirements
- R1: After reset the data register reads 0, all four flags read 0, and the synchronized line level reads 1.
- R2: The receiver waits for the synchronized line to read 0 on a sample tick. It then samples every bit at its centre, 8 ticks into the bit. Data is taken least significant bit first. A clean frame that ends while ready is 0 copies the word into the data register and sets ready to 1.
- R3: If the start bit reads 1 at its centre sample, it is treated as noise. No flag changes, the data register keeps its value, and the receiver goes back to waiting.
- R4: When parity is enabled, the bit after the eighth data bit is checked. In even mode the data bits plus the parity bit hold an even number of ones. In odd mode they hold an odd number.
- R5: If ready is 1 when a frame ends, overrun is set, ready stays 1 and the data register is not changed.
- R6: A 0 at the stop-bit centre with no overrun sets the framing flag. The word is still copied and ready stays 0.
- R7: A parity mismatch with no overrun sets the parity flag. The word is still copied and ready stays 0.
- R8: A framing error and a parity error in the same frame with no overrun set both flags, copy the word and leave ready at 0.
- R9: Any error combination that includes overrun sets overrun plus whichever of framing and parity apply. It keeps ready at 1 and leaves the data register unchanged.
- R10: While the line is held low, the receiver keeps framing all-zero words. A framing flag cleared by the host is set again by the next such frame.
- R11: Each flag has its own one-cycle clear strobe, and a strobe clears only its own flag. When a clear and a set of the same flag fall in the same cycle, the flag ends up set.
- R12: The line level output follows the input pin through two register stages. A change on the pin shows after the second rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Sample enable, sixteen pulses per bit period |
| rx_pin | input | 1 | Asynchronous serial input, idles high |
| par_en | input | 1 | 1 expects a parity bit after the data bits |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| clr_ready | input | 1 | One-cycle clear of the ready flag |
| clr_overrun | input | 1 | One-cycle clear of the overrun flag |
| clr_frame | input | 1 | One-cycle clear of the framing flag |
| clr_parity | input | 1 | One-cycle clear of the parity flag |
| rx_data | output | 8 | Data register holding the last copied word |
| flag_ready | output | 1 | A new word waits in the data register |
| flag_overrun | output | 1 | A frame was lost because ready was still set |
| flag_frame | output | 1 | The stop bit was sampled as 0 |
| flag_parity | output | 1 | The parity bit did not match the selected sense |
| line_level | output | 1 | Synchronized level of rx_pin |

## Verification
The bench instantiates the block with its default parameters:

- 8 data bits,
- sixteen samples per bit,
- two synchronizer stages,
- parity logic present.

It pulses the sample enable on every fourth clock, so a bit lasts 64 clocks and a full break sequence of several frames fits in a short run. Because parity logic is built in, both parity senses can be tested, as can every combination of the overrun, framing and parity errors. The four-clock tick spacing leaves enough room to check that a glitch a quarter bit long is rejected at the centre of the start bit. It also confirms that the line drop left after a bad stop bit does not produce a false frame.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP
   } srx_state_e;

   typedef struct packed {
      logic fe;
      logic pe;
   } srx_err_t;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] chain;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RESET_VAL;
               else        chain[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign dout = chain[STAGES-1];

endmodule

// File: rtl/srx_frame.sv
module srx_frame
   import srx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rx_s,
   input  logic              par_en,
   input  logic              par_odd,
   output logic              done,
   output logic [DATA_W-1:0] word,
   output srx_err_t          err
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(OVERSAMPLE - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   srx_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bidx;
   logic [DATA_W-1:0] shreg;
   logic              pbit;
   logic              par_use;
   logic              at_centre;

   generate
      if (PARITY_SUPPORT) begin : g_par
         assign par_use = par_en;
      end else begin : g_nopar
         assign par_use = 1'b0;
      end
   endgenerate

   assign at_centre = (cnt == CNT_FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_WAIT;
         cnt    <= '0;
         bidx   <= '0;
         shreg  <= '0;
         pbit   <= 1'b0;
         done   <= 1'b0;
         err    <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (state)
               ST_WAIT: begin
                  if (!rx_s) begin
                     cnt   <= '0;
                     state <= ST_START;
                  end
               end
               ST_START: begin
                  if (cnt == CNT_MID) begin
                     cnt  <= '0;
                     bidx <= '0;
                     if (rx_s) state <= ST_WAIT;
                     else      state <= ST_DATA;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_DATA: begin
                  if (at_centre) begin
                     cnt   <= '0;
                     shreg <= {rx_s, shreg[DATA_W-1:1]};
                     if (bidx == BIT_LAST) state <= par_use ? ST_PAR : ST_STOP;
                     else                  bidx  <= bidx + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_PAR: begin
                  if (at_centre) begin
                     cnt   <= '0;
                     pbit  <= rx_s;
                     state <= ST_STOP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (at_centre) begin
                     cnt    <= '0;
                     state  <= ST_WAIT;
                     done   <= 1'b1;
                     err.fe <= ~rx_s;
                     err.pe <= par_use & ((^shreg ^ pbit) != par_odd);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: state <= ST_WAIT;
            endcase
         end
      end
   end

   assign word = shreg;

endmodule

// File: rtl/srx_flags.sv
module srx_flags
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] word,
   input  srx_err_t          err,
   input  logic              clr_ready,
   input  logic              clr_overrun,
   input  logic              clr_frame,
   input  logic              clr_parity,
   output logic [DATA_W-1:0] data_q,
   output logic              ready,
   output logic              overrun,
   output logic              frame_err,
   output logic              parity_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q     <= '0;
         ready      <= 1'b0;
         overrun    <= 1'b0;
         frame_err  <= 1'b0;
         parity_err <= 1'b0;
      end else begin
         if (clr_ready)   ready      <= 1'b0;
         if (clr_overrun) overrun    <= 1'b0;
         if (clr_frame)   frame_err  <= 1'b0;
         if (clr_parity)  parity_err <= 1'b0;
         if (done) begin
            if (err.fe) frame_err  <= 1'b1;
            if (err.pe) parity_err <= 1'b1;
            if (ready) begin
               overrun <= 1'b1;
               ready   <= 1'b1;
            end else begin
               data_q <= word;
               if (!err.fe && !err.pe) ready <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core
   import srx_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int OVERSAMPLE     = 16,
   parameter int SYNC_STAGES    = 2,
   parameter bit PARITY_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick16,
   input  logic              rx_pin,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              clr_ready,
   input  logic              clr_overrun,
   input  logic              clr_frame,
   input  logic              clr_parity,
   output logic [DATA_W-1:0] rx_data,
   output logic              flag_ready,
   output logic              flag_overrun,
   output logic              flag_frame,
   output logic              flag_parity,
   output logic              line_level
);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 2) begin : g_bad_dw
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic              rx_s;
   logic              frm_done;
   logic [DATA_W-1:0] frm_word;
   srx_err_t          frm_err;

   srx_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rx_pin),
      .dout  (rx_s)
   );

   srx_frame #(
      .DATA_W         (DATA_W),
      .OVERSAMPLE     (OVERSAMPLE),
      .PARITY_SUPPORT (PARITY_SUPPORT)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick16),
      .rx_s    (rx_s),
      .par_en  (par_en),
      .par_odd (par_odd),
      .done    (frm_done),
      .word    (frm_word),
      .err     (frm_err)
   );

   srx_flags #(
      .DATA_W (DATA_W)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (frm_done),
      .word        (frm_word),
      .err         (frm_err),
      .clr_ready   (clr_ready),
      .clr_overrun (clr_overrun),
      .clr_frame   (clr_frame),
      .clr_parity  (clr_parity),
      .data_q      (rx_data),
      .ready       (flag_ready),
      .overrun     (flag_overrun),
      .frame_err   (flag_frame),
      .parity_err  (flag_parity)
   );

   assign line_level = rx_s;

endmodule

// File: rtl/srx_core_chk.sv
module srx_core_chk
   import srx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              frm_done,
   input srx_err_t          frm_err,
   input logic              clr_frame,
   input logic              clr_parity,
   input logic [DATA_W-1:0] rx_data,
   input logic              flag_ready,
   input logic              flag_overrun,
   input logic              flag_frame,
   input logic              flag_parity
);

   // R2
   a_r2_clean_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !flag_ready && !frm_err.fe && !frm_err.pe |=> flag_ready);

   // R5
   a_r5_overrun_holds: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && flag_ready |=> flag_overrun && flag_ready && $stable(rx_data));

   // R6, R7, R8
   a_r8_error_blocks_ready: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && !flag_ready && (frm_err.fe || frm_err.pe) |=> !flag_ready);

   // R9
   a_r9_overrun_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_overrun) |-> $past(frm_done) && $past(flag_ready));

   // R11
   a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      frm_done && frm_err.fe && clr_frame |=> flag_frame);

   // R11
   a_r11_clear_parity: assert property (@(posedge clk) disable iff (!rst_n)
      clr_parity && !frm_done |=> !flag_parity);

   // R6
   a_r6_frame_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_frame) |-> $past(frm_done) && $past(frm_err.fe));

endmodule

bind serial_rx_core srx_core_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frm_done     (frm_done),
   .frm_err      (frm_err),
   .clr_frame    (clr_frame),
   .clr_parity   (clr_parity),
   .rx_data      (rx_data),
   .flag_ready   (flag_ready),
   .flag_overrun (flag_overrun),
   .flag_frame   (flag_frame),
   .flag_parity  (flag_parity)
);

// File: tb/serial_rx_core_tb_top.sv
`timescale 1ns/1ps
module serial_rx_core_tb_top;

   localparam int TICK_DIV = 4;
   localparam int BITCLK   = 16 * TICK_DIV;

   typedef struct {
      logic [7:0] d;
      bit         r;
      bit         o;
      bit         f;
      bit         p;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rx_pin = 1'b1;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       clr_ready = 1'b0;
   logic       clr_overrun = 1'b0;
   logic       clr_frame = 1'b0;
   logic       clr_parity = 1'b0;
   logic [7:0] rx_data;
   logic       flag_ready, flag_overrun, flag_frame, flag_parity, line_level;

   int   n_checks = 0;
   int   n_bad = 0;
   int   div = 0;
   exp_t sb_q[$];

   always #2.5 clk = ~clk;

   always @(posedge clk) begin
      div    <= (div == TICK_DIV - 1) ? 0 : div + 1;
      tick16 <= (div == TICK_DIV - 1);
   end

   serial_rx_core dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick16       (tick16),
      .rx_pin       (rx_pin),
      .par_en       (par_en),
      .par_odd      (par_odd),
      .clr_ready    (clr_ready),
      .clr_overrun  (clr_overrun),
      .clr_frame    (clr_frame),
      .clr_parity   (clr_parity),
      .rx_data      (rx_data),
      .flag_ready   (flag_ready),
      .flag_overrun (flag_overrun),
      .flag_frame   (flag_frame),
      .flag_parity  (flag_parity),
      .line_level   (line_level)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         @(negedge clk);
         if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            chk({e.tag, " data"},    32'(rx_data),      32'(e.d));
            chk({e.tag, " ready"},   32'(flag_ready),   32'(e.r));
            chk({e.tag, " overrun"}, 32'(flag_overrun), 32'(e.o));
            chk({e.tag, " frame"},   32'(flag_frame),   32'(e.f));
            chk({e.tag, " parity"},  32'(flag_parity),  32'(e.p));
         end
      end
   end

   task automatic expect_state(input logic [7:0] d, input bit r, input bit o,
                               input bit f, input bit p, input string tag);
      exp_t e;
      e.d = d; e.r = r; e.o = o; e.f = f; e.p = p; e.tag = tag;
      sb_q.push_back(e);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic hold_bit(input logic b);
      rx_pin = b;
      repeat (BITCLK) @(negedge clk);
   endtask

   // start, 8 data bits LSB first, optional parity, stop, two idle bits
   task automatic send_frame(input logic [7:0] d, input bit pbad, input logic stopv);
      logic pb;
      pb = (^d) ^ par_odd ^ pbad;
      hold_bit(1'b0);
      for (int i = 0; i < 8; i++) hold_bit(d[i]);
      if (par_en) hold_bit(pb);
      hold_bit(stopv);
      hold_bit(1'b1);
      hold_bit(1'b1);
   endtask

   task automatic clear(input bit r, input bit o, input bit f, input bit p);
      clr_ready = r; clr_overrun = o; clr_frame = f; clr_parity = p;
      @(negedge clk);
      clr_ready = 1'b0; clr_overrun = 1'b0; clr_frame = 1'b0; clr_parity = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      expect_state(8'h00, 0, 0, 0, 0, "R1 reset");
      chk("R1 line level", 32'(line_level), 32'd1);

      // R2 clean frame, no parity
      send_frame(8'hA5, 0, 1'b1);
      expect_state(8'hA5, 1, 0, 0, 0, "R2 clean A5");
      clear(1, 0, 0, 0);
      expect_state(8'hA5, 0, 0, 0, 0, "R11 clear ready");

      // R4 even parity correct
      par_en = 1'b1; par_odd = 1'b0;
      send_frame(8'h3C, 0, 1'b1);
      expect_state(8'h3C, 1, 0, 0, 0, "R4 even ok");
      clear(1, 0, 0, 0);
      // R4 odd parity correct
      par_odd = 1'b1;
      send_frame(8'h81, 0, 1'b1);
      expect_state(8'h81, 1, 0, 0, 0, "R4 odd ok");
      clear(1, 0, 0, 0);

      // R7 parity error alone (even)
      par_odd = 1'b0;
      send_frame(8'h55, 1, 1'b1);
      expect_state(8'h55, 0, 0, 0, 1, "R7 parity only");
      clear(0, 0, 0, 1);

      // R6 framing error alone, no parity
      par_en = 1'b0;
      send_frame(8'h12, 0, 1'b0);
      expect_state(8'h12, 0, 0, 1, 0, "R6 framing only");
      clear(0, 0, 1, 0);

      // R8 framing + parity
      par_en = 1'b1;
      send_frame(8'h6E, 1, 1'b0);
      expect_state(8'h6E, 0, 0, 1, 1, "R8 framing+parity");
      clear(0, 0, 1, 0);
      expect_state(8'h6E, 0, 0, 0, 1, "R11 frame clear only");
      clear(0, 0, 0, 1);

      // R5 overrun alone
      par_en = 1'b0;
      send_frame(8'h11, 0, 1'b1);
      expect_state(8'h11, 1, 0, 0, 0, "R5 first word");
      send_frame(8'h22, 0, 1'b1);
      expect_state(8'h11, 1, 1, 0, 0, "R5 overrun");
      clear(0, 1, 0, 0);
      expect_state(8'h11, 1, 0, 0, 0, "R11 overrun clear only");
      clear(1, 0, 0, 0);

      // R9 overrun + framing + parity
      par_en = 1'b1;
      send_frame(8'h33, 0, 1'b1);
      expect_state(8'h33, 1, 0, 0, 0, "R9 first word");
      send_frame(8'h44, 1, 1'b0);
      expect_state(8'h33, 1, 1, 1, 1, "R9 all errors");
      clear(1, 1, 1, 1);
      expect_state(8'h33, 0, 0, 0, 0, "R11 clear all");

      // R3 short glitch on the line is ignored
      par_en = 1'b0;
      rx_pin = 1'b0;
      repeat (4 * TICK_DIV) @(negedge clk);
      rx_pin = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      expect_state(8'h33, 0, 0, 0, 0, "R3 glitch ignored");
      send_frame(8'h5A, 0, 1'b1);
      expect_state(8'h5A, 1, 0, 0, 0, "R3 frame after glitch");
      clear(1, 0, 0, 0);

      // R12 synchronizer delay, then R10 break
      rx_pin = 1'b0;
      @(negedge clk);
      chk("R12 level after one edge", 32'(line_level), 32'd1);
      @(negedge clk);
      chk("R12 level after two edges", 32'(line_level), 32'd0);
      repeat (11 * BITCLK - 2) @(negedge clk);
      expect_state(8'h00, 0, 0, 1, 0, "R10 break first frame");
      clear(0, 0, 1, 0);
      expect_state(8'h00, 0, 0, 0, 0, "R10 framing cleared");
      repeat (9 * BITCLK) @(negedge clk);
      expect_state(8'h00, 0, 0, 1, 0, "R10 framing re-set");
      chk("R10 line level low in break", 32'(line_level), 32'd0);
      rx_pin = 1'b1;
      repeat (16 * BITCLK) @(negedge clk);
      clear(1, 1, 1, 1);
      chk("R11 ready cleared", 32'(flag_ready), 32'd0);
      chk("R11 overrun cleared", 32'(flag_overrun), 32'd0);
      chk("R11 frame cleared", 32'(flag_frame), 32'd0);
      chk("R11 parity cleared", 32'(flag_parity), 32'd0);
      chk("R12 level back high", 32'(line_level), 32'd1);

      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule